// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the processor-side work that follows the acceptance of an interrupt. It captures the accepted interrupt number and level together with the current status word, the program counter, the system stack pointer and a two-bit length class for the instruction that detected the event. It then runs a fixed sequence of steps.

First it derives the return address from the length class. It pushes the status word and then the return address onto the system stack through a word write port. It lowers the stack pointer by eight and publishes a patched status word, in which the level mask field holds the accepted level and the stack-select flag is cleared. It reads the handler address from a vector table and loads it into the program counter. In the cycle of that load it raises a re-evaluation pulse, so that arbitration logic checks pending events again before the handler's first instruction executes.

The FSM has seven states: `ST_IDLE`, `ST_SAVE_PS`, `ST_SAVE_RA`, `ST_DROP_SP`, `ST_SET_MASK`, `ST_GET_VEC` and `ST_LOAD_PC`. Its transitions are:
- `ST_IDLE` goes to `ST_SAVE_PS` on `acc_valid`.
- `ST_SAVE_PS` goes to `ST_SAVE_RA`, and `ST_SAVE_RA` goes to `ST_DROP_SP`, each on `wr_ready`.
- `ST_DROP_SP` goes to `ST_SET_MASK` unconditionally.
- `ST_SET_MASK` goes to `ST_GET_VEC` unconditionally.
- `ST_GET_VEC` goes to `ST_LOAD_PC` on `rd_ready`.
- `ST_LOAD_PC` goes to `ST_IDLE` unconditionally.

Top module: `irq_entry_seq`

## Requirements
- R1: `busy` is high from the cycle after an accepted `acc_valid` (sampled in `ST_IDLE`) through the cycle of the PC load. Any `acc_valid` seen while `busy` is high is ignored and starts no further sequence.
- R2: The return address is `pc_in`+2 for length class 0, +4 for class 1, +6 for class 2, and +2 for class 3.
- R3: The first stack write stores the captured status word at `ssp_in`-4. The second stores the return address at `ssp_in`-8. No other writes occur.
- R4: A pending write holds `wr_req`, `wr_addr` and `wr_data` unchanged until `wr_ready` is high at a clock edge.
- R5: After both writes, `ssp_we` pulses for one cycle with `ssp_out` = `ssp_in`-8.
- R6: Next, `ps_we` pulses for one cycle. `ps_out` equals the captured status word with bits [20:16] replaced by the accepted level and bit 5 (stack select) forced to 0, and all other bits unchanged.
- R7: The vector is read at `vec_base` + (255 - number) × 4. `rd_req` stays high until `rd_ready`, and the word on `rd_data` in that cycle is taken.
- R8: `pc_we` pulses with `pc_out` equal to the fetched word as the final step. `reeval` pulses in exactly that cycle.
- R9: An `acc_valid` held high through the PC load is accepted in the idle cycle that follows, and `busy` rises again one cycle later.
- R10: After reset, `busy`, `wr_req`, `rd_req`, `ssp_we`, `ps_we`, `pc_we` and `reeval` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Accepted-interrupt strobe |
| acc_num | input | NUM_W | Accepted interrupt number |
| acc_level | input | LVL_W | Accepted interrupt level |
| ps_in | input | WORD_W | Current status word |
| pc_in | input | WORD_W | Address of the detecting instruction |
| len_class | input | 2 | Length class of the detecting instruction |
| ssp_in | input | WORD_W | Current system stack pointer |
| vec_base | input | WORD_W | Vector table base address |
| busy | output | 1 | Sequence in progress |
| wr_req | output | 1 | Stack write request |
| wr_addr | output | WORD_W | Stack write address |
| wr_data | output | WORD_W | Stack write data |
| wr_ready | input | 1 | Write accepted |
| rd_req | output | 1 | Vector read request |
| rd_addr | output | WORD_W | Vector read address |
| rd_ready | input | 1 | Read data valid |
| rd_data | input | WORD_W | Vector read data |
| ssp_we | output | 1 | Stack pointer update strobe |
| ssp_out | output | WORD_W | New stack pointer |
| ps_we | output | 1 | Status word update strobe |
| ps_out | output | WORD_W | New status word |
| pc_we | output | 1 | PC load strobe |
| pc_out | output | WORD_W | New PC |
| reeval | output | 1 | Re-check pending events |

## Verification
The bench builds the block with its defaults: 32-bit words, 8-bit numbers, 5-bit levels, the mask field at bit 16 and the stack-select flag at bit 5. The 8-bit number width lets numbers 0 and 255 reach both ends of the vector table, at the base plus 1020 and at the base itself. The 5-bit level lets levels 0 and 31 fill the mask field with all zeros and all ones next to preset neighbouring bits. Varying memory wait counts exercise the hold behaviour on both ports.

// File: rtl/irq_entry_pkg.sv
`timescale 1ns/1ps
package irq_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SAVE_PS  = 3'd1,
        ST_SAVE_RA  = 3'd2,
        ST_DROP_SP  = 3'd3,
        ST_SET_MASK = 3'd4,
        ST_GET_VEC  = 3'd5,
        ST_LOAD_PC  = 3'd6
    } entry_state_t;

    typedef enum logic [1:0] {
        LEN_SHORT = 2'd0,
        LEN_MID   = 2'd1,
        LEN_LONG  = 2'd2,
        LEN_RSVD  = 2'd3
    } len_class_t;

    localparam int STACK_FRAME_BYTES = 8;
    localparam int WORD_BYTES        = 4;

endpackage

// File: rtl/irq_ret_addr.sv
`timescale 1ns/1ps
module irq_ret_addr
    import irq_entry_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] pc,
    input  logic [1:0]        len_class,
    output logic [WORD_W-1:0] ret_addr
);
    logic [WORD_W-1:0] step;

    always_comb begin
        unique case (len_class_t'(len_class))
            LEN_MID:  step = WORD_W'(4);
            LEN_LONG: step = WORD_W'(6);
            default:  step = WORD_W'(2);
        endcase
    end

    assign ret_addr = pc + step;
endmodule

// File: rtl/irq_vec_addr.sv
`timescale 1ns/1ps
module irq_vec_addr
    import irq_entry_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NUM_W  = 8
) (
    input  logic [WORD_W-1:0] base,
    input  logic [NUM_W-1:0]  num,
    output logic [WORD_W-1:0] addr
);
    // Table runs downward: the highest number sits at the base.
    // (2^NUM_W - 1) - num is the bitwise inverse of num.
    logic [NUM_W-1:0]  slot;
    logic [WORD_W-1:0] offset;

    assign slot   = ~num;
    assign offset = WORD_W'(slot) * WORD_W'(WORD_BYTES);
    assign addr   = base + offset;
endmodule

// File: rtl/irq_ps_patch.sv
`timescale 1ns/1ps
module irq_ps_patch #(
    parameter int WORD_W  = 32,
    parameter int LVL_W   = 5,
    parameter int ILM_LSB = 16,
    parameter int S_BIT   = 5
) (
    input  logic [WORD_W-1:0] ps_old,
    input  logic [LVL_W-1:0]  level,
    output logic [WORD_W-1:0] ps_new
);
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (i == S_BIT) begin : g_sel
            assign ps_new[i] = 1'b0;
        end else if (i >= ILM_LSB && i < ILM_LSB + LVL_W) begin : g_mask
            assign ps_new[i] = level[i - ILM_LSB];
        end else begin : g_keep
            assign ps_new[i] = ps_old[i];
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
`timescale 1ns/1ps
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int NUM_W   = 8,
    parameter int LVL_W   = 5,
    parameter int ILM_LSB = 16,
    parameter int S_BIT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [NUM_W-1:0]  acc_num,
    input  logic [LVL_W-1:0]  acc_level,
    input  logic [WORD_W-1:0] ps_in,
    input  logic [WORD_W-1:0] pc_in,
    input  logic [1:0]        len_class,
    input  logic [WORD_W-1:0] ssp_in,
    input  logic [WORD_W-1:0] vec_base,
    output logic              busy,
    output logic              wr_req,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic [WORD_W-1:0] rd_data,
    output logic              ssp_we,
    output logic [WORD_W-1:0] ssp_out,
    output logic              ps_we,
    output logic [WORD_W-1:0] ps_out,
    output logic              pc_we,
    output logic [WORD_W-1:0] pc_out,
    output logic              reeval
);
    localparam logic [WORD_W-1:0] PS_SLOT = WORD_W'(WORD_BYTES);
    localparam logic [WORD_W-1:0] FRAME   = WORD_W'(STACK_FRAME_BYTES);

    entry_state_t      state, state_nx;
    logic [NUM_W-1:0]  num_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [WORD_W-1:0] ps_q, ra_q, ssp_q, base_q, vec_q;
    logic [WORD_W-1:0] ret_now, vec_addr, ps_patched;

    irq_ret_addr #(.WORD_W(WORD_W)) u_ret (
        .pc        (pc_in),
        .len_class (len_class),
        .ret_addr  (ret_now)
    );

    irq_vec_addr #(.WORD_W(WORD_W), .NUM_W(NUM_W)) u_vec (
        .base (base_q),
        .num  (num_q),
        .addr (vec_addr)
    );

    irq_ps_patch #(
        .WORD_W(WORD_W), .LVL_W(LVL_W), .ILM_LSB(ILM_LSB), .S_BIT(S_BIT)
    ) u_patch (
        .ps_old (ps_q),
        .level  (lvl_q),
        .ps_new (ps_patched)
    );

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (acc_valid) state_nx = ST_SAVE_PS;
            ST_SAVE_PS:  if (wr_ready)  state_nx = ST_SAVE_RA;
            ST_SAVE_RA:  if (wr_ready)  state_nx = ST_DROP_SP;
            ST_DROP_SP:  state_nx = ST_SET_MASK;
            ST_SET_MASK: state_nx = ST_GET_VEC;
            ST_GET_VEC:  if (rd_ready)  state_nx = ST_LOAD_PC;
            ST_LOAD_PC:  state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // State register and captured context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            num_q  <= '0;
            lvl_q  <= '0;
            ps_q   <= '0;
            ra_q   <= '0;
            ssp_q  <= '0;
            base_q <= '0;
            vec_q  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && acc_valid) begin
                num_q  <= acc_num;
                lvl_q  <= acc_level;
                ps_q   <= ps_in;
                ra_q   <= ret_now;
                ssp_q  <= ssp_in;
                base_q <= vec_base;
            end
            if (state == ST_GET_VEC && rd_ready) begin
                vec_q <= rd_data;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busy    = (state != ST_IDLE);
        wr_req  = 1'b0;
        wr_addr = ssp_q - PS_SLOT;
        wr_data = ps_q;
        rd_req  = 1'b0;
        rd_addr = vec_addr;
        ssp_we  = 1'b0;
        ssp_out = ssp_q - FRAME;
        ps_we   = 1'b0;
        ps_out  = ps_patched;
        pc_we   = 1'b0;
        pc_out  = vec_q;
        reeval  = 1'b0;
        unique case (state)
            ST_SAVE_PS: begin
                wr_req = 1'b1;
            end
            ST_SAVE_RA: begin
                wr_req  = 1'b1;
                wr_addr = ssp_q - FRAME;
                wr_data = ra_q;
            end
            ST_DROP_SP:  ssp_we = 1'b1;
            ST_SET_MASK: ps_we  = 1'b1;
            ST_GET_VEC:  rd_req = 1'b1;
            ST_LOAD_PC: begin
                pc_we  = 1'b1;
                reeval = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq_chk.sv
`timescale 1ns/1ps
module irq_entry_seq_chk #(
    parameter int WORD_W = 32,
    parameter int S_BIT  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              wr_req,
    input logic              wr_ready,
    input logic [WORD_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic              rd_req,
    input logic              rd_ready,
    input logic [WORD_W-1:0] rd_data,
    input logic              ssp_we,
    input logic [WORD_W-1:0] ssp_out,
    input logic              ps_we,
    input logic [WORD_W-1:0] ps_out,
    input logic              pc_we,
    input logic [WORD_W-1:0] pc_out,
    input logic              reeval
);
    localparam logic [WORD_W-1:0] S_MASK = WORD_W'(1) << S_BIT;

    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ready) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ready) |=> rd_req);

    assert_sp_after_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ssp_we |-> ($past(wr_req) && $past(wr_ready) && $past(wr_addr) == ssp_out));

    assert_mask_after_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ps_we |-> ($past(ssp_we) && (ps_out & S_MASK) == '0));

    assert_pc_from_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> ($past(rd_req && rd_ready) && pc_out == $past(rd_data)));

    assert_reeval_with_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reeval |-> (pc_we && busy));

    assert_idle_after_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> !busy);

    assert_one_action_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_req, ssp_we, ps_we, rd_req, pc_we}));

    assert_strobes_need_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req || rd_req || ssp_we || ps_we || pc_we) |-> busy);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.WORD_W(WORD_W), .S_BIT(S_BIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .wr_req   (wr_req),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_req   (rd_req),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .ssp_we   (ssp_we),
    .ssp_out  (ssp_out),
    .ps_we    (ps_we),
    .ps_out   (ps_out),
    .pc_we    (pc_we),
    .pc_out   (pc_out),
    .reeval   (reeval)
);

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [7:0]  acc_num = '0;
    logic [4:0]  acc_level = '0;
    logic [31:0] ps_in = '0, pc_in = '0, ssp_in = '0, vec_base = '0;
    logic [1:0]  len_class = '0;
    logic        busy, wr_req, rd_req, ssp_we, ps_we, pc_we, reeval;
    logic [31:0] wr_addr, wr_data, rd_addr, ssp_out, ps_out, pc_out;
    logic        wr_ready = 1'b0, rd_ready = 1'b0;
    logic [31:0] rd_data = '0;

    int checks = 0, fails = 0, cycles = 0;
    int wr_wait = 0, rd_wait = 0, wr_cnt = 0, rd_cnt = 0;

    typedef struct { int kind; logic [31:0] addr; logic [31:0] data; } item_t;
    item_t expq[$];

    always #10 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_num(acc_num),
        .acc_level(acc_level), .ps_in(ps_in), .pc_in(pc_in), .len_class(len_class),
        .ssp_in(ssp_in), .vec_base(vec_base), .busy(busy), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data), .ssp_we(ssp_we),
        .ssp_out(ssp_out), .ps_we(ps_we), .ps_out(ps_out), .pc_we(pc_we),
        .pc_out(pc_out), .reeval(reeval)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory responder with programmable wait counts
    always @(negedge clk) begin
        if (wr_req && !wr_ready) begin
            if (wr_cnt >= wr_wait) begin wr_ready = 1'b1; wr_cnt = 0; end
            else wr_cnt++;
        end else wr_ready = 1'b0;
        if (rd_req && !rd_ready) begin
            if (rd_cnt >= rd_wait) begin
                rd_ready = 1'b1; rd_data = mem_word(rd_addr); rd_cnt = 0;
            end else rd_cnt++;
        end else begin
            rd_ready = 1'b0; rd_data = 32'h0BAD_0BAD;
        end
    end

    // Monitor: pops the scoreboard as results appear
    task automatic observe(input int kind, input logic [31:0] a, input logic [31:0] d);
        item_t e;
        string tag;
        tag = (kind == 0) ? "R3" : (kind == 1) ? "R5" : (kind == 2) ? "R6" : "R8";
        if (expq.size() == 0) begin
            check(1'b0, {tag, " unexpected"}, d, 32'h0);
            return;
        end
        e = expq.pop_front();
        check(e.kind == kind, {tag, " order"}, kind, e.kind);
        check(e.addr == a, {tag, " addr"}, a, e.addr);
        check(e.data == d, {tag, " data"}, d, e.data);
    endtask

    always begin
        @(negedge clk);
        #5;
        if (rst_n) begin
            if (wr_req && wr_ready) observe(0, wr_addr, wr_data);
            if (ssp_we) observe(1, 32'h0, ssp_out);
            if (ps_we)  observe(2, 32'h0, ps_out);
            if (pc_we)  observe(3, 32'h0, pc_out);
            if (pc_we || reeval) check(pc_we == reeval, "R8 reeval with pc", reeval, pc_we);
        end
    end

    task automatic push_expect(input logic [7:0] num, input logic [4:0] lvl,
        input logic [31:0] ps, input logic [31:0] pc, input logic [1:0] len,
        input logic [31:0] ssp, input logic [31:0] base);
        logic [31:0] ra, pp, va;
        ra = pc + ((len == 2'd1) ? 32'd4 : (len == 2'd2) ? 32'd6 : 32'd2); // R2
        pp = ps;
        pp[20:16] = lvl;
        pp[5] = 1'b0;
        va = base + (32'd255 - {24'd0, num}) * 32'd4;
        expq.push_back('{0, ssp - 32'd4, ps});
        expq.push_back('{0, ssp - 32'd8, ra});
        expq.push_back('{1, 32'h0, ssp - 32'd8});
        expq.push_back('{2, 32'h0, pp});
        expq.push_back('{3, 32'h0, mem_word(va)});
    endtask

    task automatic drive(input logic [7:0] num, input logic [4:0] lvl,
        input logic [31:0] ps, input logic [31:0] pc, input logic [1:0] len,
        input logic [31:0] ssp, input logic [31:0] base);
        acc_valid = 1'b1; acc_num = num; acc_level = lvl; ps_in = ps;
        pc_in = pc; len_class = len; ssp_in = ssp; vec_base = base;
    endtask

    task automatic scramble();
        acc_valid = 1'b0; ps_in = 32'hDEAD_BEEF; pc_in = 32'h1111_0000;
        ssp_in = 32'h7777_0000; vec_base = 32'h5555_0000; len_class = 2'd3;
    endtask

    task automatic entry(input logic [7:0] num, input logic [4:0] lvl,
        input logic [31:0] ps, input logic [31:0] pc, input logic [1:0] len,
        input logic [31:0] ssp, input logic [31:0] base);
        push_expect(num, lvl, ps, pc, len, ssp, base);
        @(negedge clk);
        drive(num, lvl, ps, pc, len, ssp, base);
        @(negedge clk);
        scramble();
        check(busy == 1'b1, "R1 busy after accept", busy, 1'b1);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
        check(expq.size() == 0, "R8 sequence complete", expq.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, wr_req, rd_req, ssp_we, ps_we, pc_we, reeval} == 7'b0,
              "R10 reset state", {busy, wr_req, rd_req, ssp_we, ps_we, pc_we, reeval}, 0);

        // R2 each length class, varied waits (R4, R7)
        entry(8'd10, 5'd3,  32'h0000_0020, 32'h0000_1000, 2'd0, 32'h0008_0000, 32'h000F_0000); wait_idle();
        wr_wait = 2; rd_wait = 3;
        entry(8'd77, 5'd17, 32'hFFFF_FFFF, 32'h0000_2002, 2'd1, 32'h0008_0100, 32'h000F_0400); wait_idle();
        wr_wait = 0; rd_wait = 1;
        entry(8'd200, 5'd9, 32'h1234_5678, 32'hFFFF_FFFC, 2'd2, 32'h0000_0004, 32'h0010_0000); wait_idle();
        wr_wait = 4; rd_wait = 0;
        entry(8'd1, 5'd30, 32'h8000_0021, 32'h0000_3000, 2'd3, 32'h0009_0000, 32'h0020_0000); wait_idle();

        // R7 table ends and R6 level extremes
        wr_wait = 1; rd_wait = 2;
        entry(8'd0,   5'd31, 32'h0000_0000, 32'h0000_4000, 2'd0, 32'h000A_0000, 32'h0030_0000); wait_idle();
        entry(8'd255, 5'd0,  32'h001F_0020, 32'h0000_5000, 2'd1, 32'h000A_0100, 32'h0030_0000); wait_idle();

        // R1 strobes during busy are ignored
        wr_wait = 3;
        entry(8'd40, 5'd12, 32'h0A0A_0A0A, 32'h0000_6000, 2'd2, 32'h000B_0000, 32'h0040_0000);
        drive(8'd99, 5'd1, 32'h5A5A_5A5A, 32'h0000_7000, 2'd0, 32'h000C_0000, 32'h0050_0000);
        repeat (3) @(negedge clk);
        scramble();
        wait_idle();
        repeat (6) @(negedge clk);
        check(busy == 1'b0, "R1 no extra sequence", busy, 1'b0);
        check(expq.size() == 0, "R1 nothing extra produced", expq.size(), 0);

        // R9 strobe held through the PC load starts the next entry at once
        wr_wait = 0; rd_wait = 0;
        entry(8'd5, 5'd7, 32'h0000_0FF0, 32'h0000_8000, 2'd0, 32'h000D_0000, 32'h0060_0000);
        push_expect(8'd6, 5'd4, 32'h0003_0020, 32'h0000_9000, 2'd1, 32'h000E_0000, 32'h0070_0000);
        drive(8'd6, 5'd4, 32'h0003_0020, 32'h0000_9000, 2'd1, 32'h000E_0000, 32'h0070_0000);
        while (!pc_we) @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R9 idle cycle after load", busy, 1'b0);
        @(negedge clk);
        check(busy == 1'b1, "R9 immediate restart", busy, 1'b1);
        scramble();
        wait_idle();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++; fails++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end
endmodule